// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits on the byte write port of a nonvolatile memory built from several 32 KB blocks. Each block has a protection flag. The block watches every byte write for fixed unlock, arm and release command sequences. For each write it decides, in the same cycle, one of three outcomes: the byte may go into the array, the byte starts a timed write cycle that changes no data, or the byte is swallowed with neither effect. A page write controller elsewhere reports when a timed write period ends, and that report closes any open load window.

After an arming or releasing command, a page load window opens. The flag change is held back until that window closes, whether or not any data bytes were loaded. While a block is protected, data reaches it only inside a window opened by the three-byte command. A write without that command still burns a full timed cycle, so software sees the same timing as a real write. The flags are a retained register: the ordinary reset clears the command matching, and only a separate first-power-up clear resets the flags.

Top module: `swp_sequencer`

## Requirements
- R1: After the first-power-up clear (`fresh_n` low), every bit of `prot_flags` is 0. `wr_allow` and `dummy_start` stay 0 in any cycle without `wr_stb`.
- R2: A write to an unprotected block that is not part of a command sequence raises `wr_allow` in the same cycle, with `dummy_start` low.
- R3: The arm command is three writes to the same block, compared on address bits [14:0] and the data byte: 0xAA at 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. These command bytes raise neither output. The block's flag is set from the clock edge of the next `cycle_done` onward, even when no data byte was loaded.
- R4: After a completed command, writes to any offset of that block are allowed until `cycle_done`, up to PAGE_MAX (64) bytes. Further bytes in the same window raise neither output.
- R5: A write to a protected block with no open window raises `dummy_start` and leaves `wr_allow` low.
- R6: On a protected block, the three-byte command followed by data bytes lets those bytes through, and the flag stays set after the window closes.
- R7: The release command is six writes: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. It clears the flag at the next `cycle_done`, even when no data byte was loaded.
- R8: The block index is `wr_addr[16:15]`, and bit b of `prot_flags` belongs to block b. A command or flag change in one block leaves the flags and matching state of the other blocks untouched.
- R9: A write that does not continue a partly matched command aborts the match. If that write is 0xAA@0x5555, it starts a new match. Otherwise it is handled as an ordinary write (R2 or R5).
- R10: `rst_n` low clears all partial matches and open windows but keeps `prot_flags`.
- R11: When `wr_stb` and `cycle_done` are both high in one cycle, the write is judged as if the window has already closed and the pending flag change has already been applied.
- R12: `cycle_done` while no window is open leaves every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of command matching |
| fresh_n | input | 1 | Synchronous active-low first-power-up clear of the flags |
| wr_stb | input | 1 | One-cycle byte write strobe |
| wr_addr | input | 17 | Byte address: block index above a 15-bit offset |
| wr_data | input | 8 | Write data byte |
| cycle_done | input | 1 | End of the current timed write period |
| wr_allow | output | 1 | This write may be stored in the array |
| dummy_start | output | 1 | This write starts a timed cycle that stores nothing |
| prot_flags | output | 4 | Protection flag per block |

## Verification
The end of a write period can land in the same cycle as a new write strobe. In that cycle the window closes and the flag updates while the incoming byte is being judged. The bench provokes this directly in two ways. First, it opens an unlock window and strobes a data byte together with `cycle_done`; it expects a dummy cycle instead of a stored byte. Second, it arms an unprotected block and writes to it in its closing cycle; it expects the new protection to apply already. The random phase raises `cycle_done` on about one cycle in ten across all blocks, so this collision also occurs alongside partial matches. A bench model that closes windows first and only then judges the write gives the expected results.

// File: rtl/swp_pkg.sv
// Shared constants and types for the software write protection sequencer.
// Assumes a 15-bit in-block byte offset and 8-bit data bytes.
package swp_pkg;
    localparam int OFS_W = 15;
    localparam int DAT_W = 8;

    localparam logic [OFS_W-1:0] ADR_HEAD = 15'h5555;
    localparam logic [OFS_W-1:0] ADR_KEY  = 15'h2AAA;

    localparam logic [DAT_W-1:0] DAT_HEAD    = 8'hAA;
    localparam logic [DAT_W-1:0] DAT_KEY     = 8'h55;
    localparam logic [DAT_W-1:0] DAT_ARM     = 8'hA0;
    localparam logic [DAT_W-1:0] DAT_PRE     = 8'h80;
    localparam logic [DAT_W-1:0] DAT_RELEASE = 8'h20;

    // Classification of one write against the command vocabulary
    typedef enum logic [2:0] {
        K_OTHER,
        K_HEAD,
        K_KEY,
        K_ARM,
        K_PRE,
        K_RELEASE
    } step_kind_t;

    // Per-block matching state
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_KEY,
        ST_PRE,
        ST_HEAD2,
        ST_KEY2,
        ST_LOAD
    } match_st_t;
endpackage

// File: rtl/swp_step_decode.sv
// Classifies one byte write (offset + data) as a command step or as plain data.
// Purely combinational; shared by all blocks since only the offset matters.
module swp_step_decode
    import swp_pkg::*;
(
    input  logic [OFS_W-1:0] ofs,
    input  logic [DAT_W-1:0] data,
    output step_kind_t       kind
);
    // Match the address/data pair against the five command steps
    always_comb begin
        kind = K_OTHER;
        if (ofs == ADR_KEY && data == DAT_KEY) begin
            kind = K_KEY;
        end else if (ofs == ADR_HEAD) begin
            unique case (data)
                DAT_HEAD:    kind = K_HEAD;
                DAT_ARM:     kind = K_ARM;
                DAT_PRE:     kind = K_PRE;
                DAT_RELEASE: kind = K_RELEASE;
                default:     kind = K_OTHER;
            endcase
        end
    end
endmodule

// File: rtl/swp_block_fsm.sv
// Command matcher, page window and retained protection flag for one block.
// Assumes sel is a one-cycle strobe already qualified by block index and reset,
// and that cycle_done marks the end of the write period opened by a command.
module swp_block_fsm
    import swp_pkg::*;
#(
    parameter int PAGE_MAX = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fresh_n,
    input  logic       sel,
    input  step_kind_t kind,
    input  logic       cycle_done,
    output logic       allow,
    output logic       dummy,
    output logic       flag
);
    localparam int CNT_W = $clog2(PAGE_MAX + 1);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(PAGE_MAX);

    match_st_t        st, eff_st, nxt_st;
    logic [CNT_W-1:0] cnt, nxt_cnt;
    logic             pend_set, nxt_pend;
    logic             eff_flag;
    logic             adv;

    // Apply a window close first so a same-cycle write sees the new flag
    always_comb begin
        eff_st   = st;
        eff_flag = flag;
        if (cycle_done && st == ST_LOAD) begin
            eff_st   = ST_IDLE;
            eff_flag = pend_set;
        end
    end

    // Judge the current write and compute the next matching state
    always_comb begin
        nxt_st   = eff_st;
        nxt_cnt  = cnt;
        nxt_pend = pend_set;
        allow    = 1'b0;
        dummy    = 1'b0;
        adv      = 1'b1;
        if (sel) begin
            if (eff_st == ST_LOAD) begin
                if (cnt < CAP) begin
                    allow   = 1'b1;
                    nxt_cnt = cnt + 1'b1;
                end
            end else begin
                unique case (eff_st)
                    ST_IDLE:  if (kind == K_HEAD) nxt_st = ST_HEAD; else adv = 1'b0;
                    ST_HEAD:  if (kind == K_KEY)  nxt_st = ST_KEY;  else adv = 1'b0;
                    ST_KEY: begin
                        if (kind == K_ARM) begin
                            nxt_st   = ST_LOAD;
                            nxt_pend = 1'b1;
                            nxt_cnt  = '0;
                        end else if (kind == K_PRE) begin
                            nxt_st = ST_PRE;
                        end else begin
                            adv = 1'b0;
                        end
                    end
                    ST_PRE:   if (kind == K_HEAD) nxt_st = ST_HEAD2; else adv = 1'b0;
                    ST_HEAD2: if (kind == K_KEY)  nxt_st = ST_KEY2;  else adv = 1'b0;
                    ST_KEY2: begin
                        if (kind == K_RELEASE) begin
                            nxt_st   = ST_LOAD;
                            nxt_pend = 1'b0;
                            nxt_cnt  = '0;
                        end else begin
                            adv = 1'b0;
                        end
                    end
                    default:  adv = 1'b0;
                endcase
                if (!adv) begin
                    if (kind == K_HEAD) begin
                        nxt_st = ST_HEAD;
                    end else begin
                        nxt_st = ST_IDLE;
                        allow  = !eff_flag;
                        dummy  = eff_flag;
                    end
                end
            end
        end
    end

    // Matching state, window byte count and pending flag value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            pend_set <= 1'b0;
        end else begin
            st       <= nxt_st;
            cnt      <= nxt_cnt;
            pend_set <= nxt_pend;
        end
    end

    // Retained protection flag: only the first-power-up clear resets it
    always_ff @(posedge clk) begin
        if (!fresh_n) begin
            flag <= 1'b0;
        end else if (rst_n) begin
            flag <= eff_flag;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CAP); // R4
    AST_FLAG_MOVES_AT_CLOSE: assert property (@(posedge clk) disable iff (!fresh_n)
        ($past(fresh_n) && flag != $past(flag)) |-> ($past(cycle_done) && $past(st) == ST_LOAD)); // R12
    AST_RISE_FROM_ARM: assert property (@(posedge clk) disable iff (!fresh_n)
        ($past(fresh_n) && $rose(flag)) |-> $past(pend_set)); // R3
    AST_FALL_FROM_RELEASE: assert property (@(posedge clk) disable iff (!fresh_n)
        ($past(fresh_n) && $fell(flag)) |-> !$past(pend_set)); // R7
endmodule

// File: rtl/swp_sequencer.sv
// Top of the software write protection sequencer: splits the address into
// block index and offset, classifies each write, and runs one matcher per block.
// Assumes at most one write strobe per cycle and NUM_BLK a power of two.
module swp_sequencer
    import swp_pkg::*;
#(
    parameter int NUM_BLK  = 4,
    parameter int PAGE_MAX = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           fresh_n,
    input  logic                           wr_stb,
    input  logic [$clog2(NUM_BLK)+OFS_W-1:0] wr_addr,
    input  logic [DAT_W-1:0]               wr_data,
    input  logic                           cycle_done,
    output logic                           wr_allow,
    output logic                           dummy_start,
    output logic [NUM_BLK-1:0]             prot_flags
);
    localparam int BLK_W  = $clog2(NUM_BLK);
    localparam int ADDR_W = BLK_W + OFS_W;

    logic [BLK_W-1:0]   blk_idx;
    logic [OFS_W-1:0]   ofs;
    step_kind_t         kind;
    logic [NUM_BLK-1:0] sel_v, allow_v, dummy_v;

    // Split the byte address into block index and in-block offset
    always_comb begin
        blk_idx = wr_addr[ADDR_W-1:OFS_W];
        ofs     = wr_addr[OFS_W-1:0];
    end

    swp_step_decode u_decode (
        .ofs  (ofs),
        .data (wr_data),
        .kind (kind)
    );

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
        // Steer the strobe to the addressed block only
        always_comb sel_v[b] = wr_stb && rst_n && (blk_idx == BLK_W'(b));

        swp_block_fsm #(.PAGE_MAX(PAGE_MAX)) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .fresh_n    (fresh_n),
            .sel        (sel_v[b]),
            .kind       (kind),
            .cycle_done (cycle_done),
            .allow      (allow_v[b]),
            .dummy      (dummy_v[b]),
            .flag       (prot_flags[b])
        );
    end

    // Merge the per-block verdicts; only the selected block can assert
    always_comb begin
        wr_allow    = |allow_v;
        dummy_start = |dummy_v;
    end

    AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_allow && dummy_start)); // R5
    AST_VERDICT_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_allow || dummy_start) |-> wr_stb); // R1
    AST_DUMMY_ONLY_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
        dummy_start |-> (prot_flags[blk_idx] || cycle_done)); // R5
    AST_ONE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(allow_v | dummy_v)); // R8
endmodule

// File: tb/test_swp_sequencer.sv
// Bench for swp_sequencer: directed corner cases, then seeded random writes,
// compared against a behavioural model written from the requirements.
module test_swp_sequencer;
    localparam int NB = 4;
    localparam int PM = 64;

    logic        clk = 1'b0;
    logic        rst_n, fresh_n, wr_stb, cycle_done;
    logic [16:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_allow, dummy_start;
    logic [NB-1:0] prot_flags;

    always #4 clk = ~clk;

    swp_sequencer #(.NUM_BLK(NB), .PAGE_MAX(PM)) i_swp_sequencer (
        .clk(clk), .rst_n(rst_n), .fresh_n(fresh_n), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .cycle_done(cycle_done),
        .wr_allow(wr_allow), .dummy_start(dummy_start), .prot_flags(prot_flags)
    );

    int errors = 0;
    int checks = 0;
    int mst [NB];
    int mcnt[NB];
    bit mpend[NB];
    logic [NB-1:0] mflag;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int kind_of(input logic [14:0] o, input logic [7:0] d);
        if (o == 15'h2AAA && d == 8'h55) return 2;
        if (o != 15'h5555) return 0;
        if (d == 8'hAA) return 1;
        if (d == 8'hA0) return 3;
        if (d == 8'h80) return 4;
        if (d == 8'h20) return 5;
        return 0;
    endfunction

    task automatic model_clear(input bit fresh);
        for (int i = 0; i < NB; i++) begin
            mst[i] = 0; mcnt[i] = 0; mpend[i] = 1'b0;
        end
        if (fresh) mflag = '0;
    endtask

    task automatic do_reset(input bit fresh);
        @(negedge clk);
        rst_n = 1'b0; fresh_n = !fresh; wr_stb = 1'b0; cycle_done = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; fresh_n = 1'b1;
        model_clear(fresh);
    endtask

    // One cycle of stimulus; checks flags, then the same-cycle verdict
    task automatic step(input bit stb, input int b, input logic [14:0] o,
                        input logic [7:0] d, input bit done, input string tag);
        bit ea, ed;
        int k, ns;
        @(negedge clk);
        check({tag, " flags"}, 32'(prot_flags), 32'(mflag));
        wr_stb = stb; wr_addr = {b[1:0], o}; wr_data = d; cycle_done = done;
        #1;
        for (int i = 0; i < NB; i++)
            if (done && mst[i] == 6) begin mst[i] = 0; mflag[i] = mpend[i]; end
        ea = 1'b0; ed = 1'b0;
        if (stb) begin
            k = kind_of(o, d);
            if (mst[b] == 6) begin
                if (mcnt[b] < PM) begin ea = 1'b1; mcnt[b]++; end
            end else begin
                ns = -1;
                case (mst[b])
                    0: if (k == 1) ns = 1;
                    1: if (k == 2) ns = 2;
                    2: if (k == 3) begin ns = 6; mpend[b] = 1'b1; mcnt[b] = 0; end
                       else if (k == 4) ns = 3;
                    3: if (k == 1) ns = 4;
                    4: if (k == 2) ns = 5;
                    5: if (k == 5) begin ns = 6; mpend[b] = 1'b0; mcnt[b] = 0; end
                    default: ;
                endcase
                if (ns < 0) begin
                    if (k == 1) ns = 1;
                    else begin ns = 0; ea = !mflag[b]; ed = mflag[b]; end
                end
                mst[b] = ns;
            end
        end
        check({tag, " allow"}, 32'(wr_allow), 32'(ea));
        check({tag, " dummy"}, 32'(dummy_start), 32'(ed));
    endtask

    task automatic arm_cmd(input int b, input string tag);
        step(1, b, 15'h5555, 8'hAA, 0, tag);
        step(1, b, 15'h2AAA, 8'h55, 0, tag);
        step(1, b, 15'h5555, 8'hA0, 0, tag);
    endtask

    task automatic release_cmd(input int b, input string tag);
        step(1, b, 15'h5555, 8'hAA, 0, tag);
        step(1, b, 15'h2AAA, 8'h55, 0, tag);
        step(1, b, 15'h5555, 8'h80, 0, tag);
        step(1, b, 15'h5555, 8'hAA, 0, tag);
        step(1, b, 15'h2AAA, 8'h55, 0, tag);
        step(1, b, 15'h5555, 8'h20, 0, tag);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: an expired run is a failed check
    initial begin
        #(8 * 200000);
        checks++; errors++;
        $display("FAIL R1 watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; fresh_n = 1'b0; wr_stb = 1'b0; cycle_done = 1'b0;
        wr_addr = '0; wr_data = '0;
        model_clear(1'b1);
        do_reset(1'b1);

        // R1: flags clear after fresh reset, no verdict without strobe
        @(negedge clk);
        check("R1 flags zero", 32'(prot_flags), 32'h0);
        check("R1 quiet allow", 32'(wr_allow), 32'h0);
        check("R1 quiet dummy", 32'(dummy_start), 32'h0);

        // R2: ordinary write to unprotected block
        step(1, 0, 15'h0123, 8'h3C, 0, "R2");
        // R3: arm block 1 with no data, then close the period
        arm_cmd(1, "R3");
        step(0, 0, 15'h0, 8'h0, 1, "R3");
        step(0, 0, 15'h0, 8'h0, 0, "R3");
        check("R3 flag set", 32'(prot_flags), 32'h2);
        // R5 / R8: blocked write on block 1, block 0 still open
        step(1, 1, 15'h0040, 8'h11, 0, "R5");
        step(1, 0, 15'h0040, 8'h11, 0, "R8");
        // R6: unlocked burst on protected block
        arm_cmd(1, "R6");
        step(1, 1, 15'h0100, 8'h01, 0, "R6");
        step(1, 1, 15'h7FFF, 8'hAA, 0, "R6");
        step(1, 1, 15'h5555, 8'h55, 0, "R6");
        step(0, 0, 15'h0, 8'h0, 1, "R6");
        step(0, 0, 15'h0, 8'h0, 0, "R6");
        // R4: 64 bytes pass, the next ones are dropped
        arm_cmd(1, "R4");
        for (int i = 0; i < PM + 2; i++) step(1, 1, 15'(i), 8'(i), 0, "R4");
        step(0, 0, 15'h0, 8'h0, 1, "R4");
        // R9: broken match becomes blocked write; AA@5555 restarts match
        step(1, 1, 15'h5555, 8'hAA, 0, "R9");
        step(1, 1, 15'h3333, 8'h12, 0, "R9");
        step(1, 1, 15'h5555, 8'hAA, 0, "R9");
        step(1, 1, 15'h5555, 8'hAA, 0, "R9");
        step(1, 1, 15'h2AAA, 8'h55, 0, "R9");
        step(1, 1, 15'h5555, 8'hA0, 0, "R9");
        step(1, 1, 15'h0200, 8'h77, 0, "R9");
        step(0, 0, 15'h0, 8'h0, 1, "R9");
        // R11: write in the closing cycle of a window sees it closed
        arm_cmd(1, "R11");
        step(1, 1, 15'h0300, 8'h44, 1, "R11");
        arm_cmd(2, "R11");
        step(1, 2, 15'h0300, 8'h44, 1, "R11");
        // R7: release block 1 with no data
        release_cmd(1, "R7");
        step(0, 0, 15'h0, 8'h0, 1, "R7");
        step(1, 1, 15'h0400, 8'h99, 0, "R7");
        // R12: close with nothing open changes nothing
        step(0, 0, 15'h0, 8'h0, 1, "R12");
        step(0, 0, 15'h0, 8'h0, 0, "R12");
        // R10: plain reset keeps flags and drops partial match
        step(1, 0, 15'h5555, 8'hAA, 0, "R10");
        step(1, 0, 15'h2AAA, 8'h55, 0, "R10");
        do_reset(1'b0);
        step(1, 0, 15'h5555, 8'hA0, 0, "R10");
        check("R10 flags kept", 32'(prot_flags), 32'h4);
        do_reset(1'b1);
        step(0, 0, 15'h0, 8'h0, 0, "R1");

        // Seeded random mix biased toward command bytes
        void'($urandom(32'h5EED));
        for (int i = 0; i < 3000; i++) begin
            int b, r;
            logic [14:0] o;
            logic [7:0]  d;
            b = int'($urandom_range(0, NB - 1));
            r = int'($urandom_range(0, 9));
            o = 15'($urandom);
            d = 8'($urandom);
            case (r)
                0, 1: begin o = 15'h5555; d = 8'hAA; end
                2, 3: begin o = 15'h2AAA; d = 8'h55; end
                4:    begin o = 15'h5555; d = 8'hA0; end
                5:    begin o = 15'h5555; d = 8'h80; end
                6:    begin o = 15'h5555; d = 8'h20; end
                default: ;
            endcase
            step(($urandom_range(0, 7) != 0), b, o, d, ($urandom_range(0, 9) == 0), "R9");
        end
        step(0, 0, 15'h0, 8'h0, 0, "R8");
        finish_run();
    end
endmodule